// File: doc/BRIEF.md
# Integer Shift Unit

This block is the shifter of a 32-bit integer execute stage. It performs a logical left shift, a logical right shift or an arithmetic right shift of a 32-bit operand. The shift distance comes from one of two places. In fixed mode it is the 5-bit amount field carried by the instruction. In variable mode it is the low five bits of a second source register.

Each request is presented for one cycle with `valid_in` high. The shifted value appears on `result` one clock later, and `valid_out` is high in that same cycle. Between requests the result register keeps its last value.

Rotates are not performed by this unit. Software builds them from two shifts and an OR. No flags or overflow indication are produced.

Top module: `shift_exec_unit`

## Requirements
- R1: While `rst_n` is low, `valid_out` is 0 and `result` is 0x00000000.
- R2: `valid_out` is high in exactly the cycle after each cycle in which `valid_in` was high at the clock edge, and low otherwise.
- R3: Kind code 2'b00 is a logical left shift that fills the vacated low bits with zeros (0x00000077 by 3 gives 0x000003B8).
- R4: Kind code 2'b01 is a logical right shift that fills the vacated high bits with zeros (0x00000003 by 2 gives 0x00000000).
- R5: Kind codes 2'b10 and 2'b11 are both an arithmetic right shift: every vacated high bit is a copy of operand bit 31.
- R6: With `amt_from_reg` at 0, the distance is `imm_amt`, and `reg_amt` has no effect on the result.
- R7: With `amt_from_reg` at 1, the distance is `reg_amt[4:0]`. `imm_amt` and `reg_amt[31:5]` have no effect on the result.
- R8: A distance of 0 returns the operand unchanged for every kind code.
- R9: In a cycle where `valid_in` is low at the clock edge, `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| valid_in | input | 1 | A shift request is present this cycle |
| shift_kind | input | 2 | 00 left logical, 01 right logical, 1x right arithmetic |
| amt_from_reg | input | 1 | 1 selects the register distance, 0 selects the instruction field |
| operand | input | 32 | Value to be shifted |
| imm_amt | input | 5 | Shift distance taken from the instruction field |
| reg_amt | input | 32 | Register value whose low five bits give the variable distance |
| valid_out | output | 1 | `result` holds a new value this cycle |
| result | output | 32 | Registered shift result |

## Verification
Each result, and the `valid_out` pulse that goes with it, is due in the cycle after the edge that captured the request. No result arrives earlier or later than that single cycle. The driver changes inputs just after a rising edge and queues the value worked out from the requirements. The monitor samples at the falling edge and takes one queued value for every `valid_out` it sees. Any extra pulse, missing pulse or shifted arrival therefore shows up as a mismatch. In idle cycles the monitor checks that `result` still equals the last delivered value.

// File: rtl/shift_exec_pkg.sv
package shift_exec_pkg;
  localparam int DATA_W = 32;
  localparam int AMT_W  = $clog2(DATA_W);

  // Kind encoding: bit 1 set means arithmetic right shift.
  typedef enum logic [1:0] {
    SK_LEFT     = 2'b00,
    SK_RIGHT_LG = 2'b01,
    SK_RIGHT_AR = 2'b10,
    SK_RIGHT_AX = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/shift_amt_select.sv
module shift_amt_select #(
  parameter int AMT_W = 5
) (
  input  logic             use_reg,
  input  logic [AMT_W-1:0] field_amt,
  input  logic [AMT_W-1:0] reg_low,
  output logic [AMT_W-1:0] amt
);
  always_comb begin
    if (use_reg) amt = reg_low;
    else         amt = field_amt;
  end
endmodule

// File: rtl/shift_barrel.sv
module shift_barrel #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          to_left,
  input  logic          fill,
  output logic [W-1:0]  dout
);
  logic [W-1:0] din_rev;
  logic [W-1:0] stage [0:SW];
  logic [W-1:0] out_rev;

  // A left shift is a right shift of the bit-reversed word.
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign din_rev[i] = din[W-1-i];
    assign out_rev[i] = stage[SW][W-1-i];
  end

  assign stage[0] = to_left ? din_rev : din;

  // One stage per distance bit; stage s moves by 2**s places.
  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stage[s+1] = amt[s] ? {{SH{fill}}, stage[s][W-1:SH]} : stage[s];
  end

  assign dout = to_left ? out_rev : stage[SW];
endmodule

// File: rtl/shift_exec_unit.sv
module shift_exec_unit
  import shift_exec_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int SW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         valid_in,
  input  logic [1:0]   shift_kind,
  input  logic         amt_from_reg,
  input  logic [W-1:0] operand,
  input  logic [SW-1:0] imm_amt,
  input  logic [W-1:0] reg_amt,
  output logic         valid_out,
  output logic [W-1:0] result
);
  logic [SW-1:0] amt_sel;
  logic          go_left;
  logic          arith;
  logic          fill_bit;
  logic [W-1:0]  shifted;
  logic [W-1:0]  result_d;
  logic [W-1:0]  result_q;
  logic          valid_q;
  logic          unused_reg_hi;

  // Only the low SW bits of the register distance are used.
  assign unused_reg_hi = ^reg_amt[W-1:SW];

  shift_amt_select #(.AMT_W(SW)) i_amt_sel (
    .use_reg  (amt_from_reg),
    .field_amt(imm_amt),
    .reg_low  (reg_amt[SW-1:0]),
    .amt      (amt_sel)
  );

  always_comb begin
    go_left  = (shift_kind == SK_LEFT);
    arith    = shift_kind[1];
    fill_bit = arith & operand[W-1];
  end

  shift_barrel #(.W(W), .SW(SW)) i_barrel (
    .din    (operand),
    .amt    (amt_sel),
    .to_left(go_left),
    .fill   (fill_bit),
    .dout   (shifted)
  );

  // Next-state: capture only on a request, otherwise hold.
  always_comb begin
    if (valid_in) result_d = shifted;
    else          result_d = result_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      result_q <= result_d;
      valid_q  <= valid_in;
    end
  end

  assign result    = result_q;
  assign valid_out = valid_q;
endmodule

// File: rtl/shift_exec_unit_chk.sv
module shift_exec_unit_chk #(
  parameter int W  = 32,
  parameter int SW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          valid_in,
  input logic [1:0]    shift_kind,
  input logic          amt_from_reg,
  input logic [W-1:0]  operand,
  input logic [SW-1:0] imm_amt,
  input logic [W-1:0]  reg_amt,
  input logic          valid_out,
  input logic [W-1:0]  result
);
  logic [SW-1:0] eff_amt;
  assign eff_amt = amt_from_reg ? reg_amt[SW-1:0] : imm_amt;

  // R1
  always_comb begin
    if (!rst_n) begin
      a_r1_reset_clear: assert (valid_out == 1'b0 && result == '0);
    end
  end

  a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out);
  a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !valid_out);

  a_r3_left_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && shift_kind == 2'b00 && !amt_from_reg)
    |=> result == $past(operand << imm_amt));

  a_r4_right_msb_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && shift_kind == 2'b01 && eff_amt != '0) |=> !result[W-1]);

  a_r5_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && shift_kind[1]) |=> result[W-1] == $past(operand[W-1]));

  a_r8_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && eff_amt == '0) |=> result == $past(operand));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> $stable(result));
endmodule

bind shift_exec_unit shift_exec_unit_chk #(.W(W), .SW(SW)) i_chk (.*);

// File: tb/test_shift_exec_unit.sv
module test_shift_exec_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_in;
  logic [1:0]  shift_kind;
  logic        amt_from_reg;
  logic [31:0] operand;
  logic [4:0]  imm_amt;
  logic [31:0] reg_amt;
  logic        valid_out;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit seen_any = 0;
  logic [31:0] last_val;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  shift_exec_unit i_shift_exec_unit (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .shift_kind(shift_kind),
    .amt_from_reg(amt_from_reg), .operand(operand), .imm_amt(imm_amt),
    .reg_amt(reg_amt), .valid_out(valid_out), .result(result)
  );

  function automatic logic [31:0] model(logic [1:0] k, logic [31:0] op, logic [4:0] a);
    case (k)
      2'b00:   return op << a;
      2'b01:   return op >> a;
      default: return $unsigned($signed(op) >>> a);
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(string req, logic [1:0] k, logic sel, logic [31:0] op,
                       logic [4:0] ia, logic [31:0] ra);
    logic [4:0] a;
    @(posedge clk); #1;
    valid_in = 1'b1; shift_kind = k; amt_from_reg = sel;
    operand = op; imm_amt = ia; reg_amt = ra;
    a = sel ? ra[4:0] : ia;
    exp_q.push_back(model(k, op, a));
    tag_q.push_back(req);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      valid_in = 1'b0; operand = 32'hDEAD_BEEF; imm_amt = 5'd7; reg_amt = 32'h1F;
    end
  endtask

  // Monitor: one queued value per valid_out; idle cycles keep the last value.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      if (valid_out) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 actual valid_out 1 expected 0");
        end else begin
          string t;
          logic [31:0] e;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, result, e);
          last_val = e;
          seen_any = 1;
        end
      end else if (seen_any) begin
        check("R9 hold", result, last_val);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; valid_in = 1'b1; shift_kind = 2'b00; amt_from_reg = 1'b0;
    operand = 32'hFFFF_FFFF; imm_amt = 5'd1; reg_amt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 valid_out", {31'd0, valid_out}, 32'd0);
    check("R1 result", result, 32'd0);
    #1 rst_n = 1'b1; valid_in = 1'b0;
    idle(2);
    check("R2 no pulse before request", {31'd0, valid_out}, 32'd0);

    drive("R3 left 0x77 by 3", 2'b00, 1'b0, 32'h0000_0077, 5'd3, 32'h0);
    drive("R3 left by 31", 2'b00, 1'b0, 32'h8000_0001, 5'd31, 32'h0);
    drive("R4 right 3 by 2", 2'b01, 1'b0, 32'h0000_0003, 5'd2, 32'h0);
    drive("R4 right zero fill", 2'b01, 1'b0, 32'hF000_0000, 5'd4, 32'h0);
    idle(2);
    drive("R5 arith negative", 2'b10, 1'b0, 32'h8000_0000, 5'd4, 32'h0);
    drive("R5 arith positive by 31", 2'b10, 1'b0, 32'h7FFF_FFFF, 5'd31, 32'h0);
    drive("R5 kind 11 arith", 2'b11, 1'b0, 32'h9000_0000, 5'd1, 32'h0);
    drive("R5 negative by 31", 2'b11, 1'b0, 32'h8000_1234, 5'd31, 32'h0);
    idle(1);
    drive("R6 field used reg ignored", 2'b00, 1'b0, 32'h0000_0001, 5'd1, 32'h0000_0007);
    drive("R7 reg low bits used", 2'b01, 1'b1, 32'h8000_0000, 5'd9, 32'hFFFF_FFE4);
    drive("R7 reg upper bits ignored", 2'b10, 1'b1, 32'hC000_0000, 5'd0, 32'hABCD_E002);
    drive("R7 field ignored", 2'b00, 1'b1, 32'h0000_0003, 5'd30, 32'h0000_0000);
    idle(3);
    drive("R8 zero left", 2'b00, 1'b0, 32'hA5A5_5A5A, 5'd0, 32'h5);
    drive("R8 zero right", 2'b01, 1'b1, 32'hA5A5_5A5A, 5'd3, 32'hFFFF_FFE0);
    drive("R8 zero arith", 2'b10, 1'b0, 32'h8765_4321, 5'd0, 32'h0);
    idle(4);
    check("R2 all results delivered", exp_q.size(), 32'd0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule